// File: doc/BRIEF.md
# Integer ALU with Stored Condition Flags

This block is a two-operand integer arithmetic and logic unit. It works on 64-bit operands and has a mode that computes on the low 32 bits only. On the clock edge after each valid operation it updates a four-bit flag register holding carry, zero, sign and overflow. The datapath result is combinational from the operands and the operation code. Each operation writes only the flags it defines and leaves the others as they were. Compare and test write the flags and do not change the destination value.

A condition selector is evaluated against the stored flags at all times. Its outcome drives a branch-taken output and the set-byte operation. Set-byte writes 0 or 1 into the low byte of the destination and keeps the upper bytes of the destination operand. The sequencer that surrounds the block supplies the destination value on `src_a`, the source value on `src_b`, and writes `result` back.

Top module: `flag_alu`

## Requirements
- R1: After reset the flag register `flags_q` is 0. Its bit order is {OF, SF, ZF, CF} (CF is bit 0). A cycle without `op_valid` leaves the flags unchanged.
- R2: Add (op 0) gives a+b. CF is the carry out of the top bit. ZF is set when the result is zero and SF is the result's sign bit. OF is set when two operands of the same sign give a sum of the other sign.
- R3: Subtract (op 1) gives a−b and negate (op 11) gives 0−a. CF is set when the unsigned minuend is below the subtrahend. OF is set on a signed out-of-range difference. ZF and SF follow the difference.
- R4: Compare (op 13) sets the flags as subtract does, and test (op 14) sets ZF and SF from a&b and clears CF and OF. For both, `result` equals `src_a` unchanged.
- R5: And (op 7), or (op 8), xor (op 6) and not (op 12) set ZF and SF from their result and clear CF and OF.
- R6: Increment (op 9) and decrement (op 10) update ZF, SF and OF and keep CF.
- R7: Multiply (op 2) returns the low half of a*b and leaves all flags unchanged.
- R8: Shift left (op 3), arithmetic right (op 4, sign fill) and logical right (op 5, zero fill) shift by `src_b` masked to 5 bits in 32-bit mode or 6 bits in 64-bit mode. A nonzero shift sets CF to the last bit shifted out, sets ZF and SF, and clears OF. A shift by zero leaves the flags unchanged.
- R9: With `op_wide` low, operations compute on bits 31:0, take flags from bit 31, and drive `result[63:32]` to zero. Compare, test and set-byte are excluded from this rule.
- R10: `cond_true` evaluates `cond_sel` against the stored flags: 0 ZF, 1 ~ZF, 2 SF, 3 ~SF, 4 ~(SF^OF)&~ZF, 5 ~(SF^OF), 6 SF^OF, 7 (SF^OF)|ZF, 8 ~CF&~ZF, 9 CF, 10 always 1, codes 11 to 15 give 0.
- R11: Set-byte (op 15) returns `src_a[63:8]`, then seven zero bits, then `cond_true`, and leaves the flags unchanged.
- R12: The flags written by an operation are visible on `flags_q` and used by `cond_true` from the clock edge that ends that operation's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present; flags may update |
| op_code | input | 4 | Operation select |
| op_wide | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| src_a | input | 64 | Destination/first operand |
| src_b | input | 64 | Source/second operand, shift count |
| cond_sel | input | 4 | Condition to evaluate |
| result | output | 64 | Value to write back to the destination |
| flags_q | output | 4 | Stored flags {OF, SF, ZF, CF} |
| cond_true | output | 1 | Selected condition holds on stored flags |

## Verification
The arithmetic paths are driven at the signed and unsigned edges: the largest positive value plus one, all ones plus one, zero minus one, the most negative value negated, and equal operands compared. These cases separate carry from overflow and ZF from SF. The same values are repeated in 32-bit mode with nonzero upper bits to show that the upper half is ignored and zero-filled. A chain of xor, arithmetic shift right by 17, and an and with 8185 on a negative value is compared against plain integer arithmetic, which shows sign fill against zero fill. Every condition code is swept after several distinct flag states. A long random stream of mixed operations and widths then tests that each operation writes only its own flags.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_MUL  = 4'd2,  OP_SHL  = 4'd3,
      OP_SAR  = 4'd4,  OP_SHR  = 4'd5,  OP_XOR  = 4'd6,  OP_AND  = 4'd7,
      OP_OR   = 4'd8,  OP_INC  = 4'd9,  OP_DEC  = 4'd10, OP_NEG  = 4'd11,
      OP_NOT  = 4'd12, OP_CMP  = 4'd13, OP_TEST = 4'd14, OP_SETB = 4'd15
   } alu_op_e;

   typedef enum logic [3:0] {
      CC_EQ = 4'd0, CC_NE = 4'd1, CC_NEG = 4'd2, CC_NNEG = 4'd3,
      CC_GT = 4'd4, CC_GE = 4'd5, CC_LT  = 4'd6, CC_LE   = 4'd7,
      CC_AB = 4'd8, CC_BL = 4'd9, CC_ALWAYS = 4'd10
   } cc_e;

   localparam int FLAG_N  = 4;
   localparam int FLAG_CF = 0;
   localparam int FLAG_ZF = 1;
   localparam int FLAG_SF = 2;
   localparam int FLAG_OF = 3;
endpackage

// File: rtl/alu_lane.sv
module alu_lane
   import flag_alu_pkg::*;
#(
   parameter int W = 64
) (
   input  alu_op_e           op,
   input  logic [W-1:0]      a,
   input  logic [W-1:0]      b,
   output logic [W-1:0]      res,
   output logic [FLAG_N-1:0] flg_new,
   output logic [FLAG_N-1:0] flg_upd
);
   localparam int SHW = $clog2(W);
   localparam int MSB = W - 1;
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ZERO = '0;
   localparam logic [FLAG_N-1:0] ALL   = '1;
   localparam logic [FLAG_N-1:0] NO_CF = 4'b1110;

   logic [W:0]         sum, diff, shl_x, shr_x;
   logic signed [W:0]  sar_x;
   logic [W-1:0]       prod, inc_r, dec_r, neg_r;
   logic [SHW-1:0]     sh;
   logic [W-1:0]       fval;
   logic               cf, of;

   assign sum   = {1'b0, a} + {1'b0, b};
   assign diff  = {1'b0, a} - {1'b0, b};
   assign prod  = a * b;
   assign inc_r = a + ONE;
   assign dec_r = a - ONE;
   assign neg_r = ZERO - a;
   assign sh    = b[SHW-1:0];
   assign shl_x = {1'b0, a} << sh;
   assign shr_x = {a, 1'b0} >> sh;
   assign sar_x = $signed({a, 1'b0}) >>> sh;

   always_comb begin
      res     = a;
      fval    = a;
      cf      = 1'b0;
      of      = 1'b0;
      flg_upd = ALL;
      unique case (op)
         OP_ADD: begin
            res = sum[W-1:0];
            cf  = sum[W];
            of  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
         end
         OP_SUB, OP_CMP: begin
            if (op == OP_SUB) res = diff[W-1:0];
            fval = diff[W-1:0];
            cf   = diff[W];
            of   = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
         end
         OP_MUL: begin
            res     = prod;
            flg_upd = '0;
         end
         OP_SHL: begin
            res     = shl_x[W-1:0];
            cf      = shl_x[W];
            flg_upd = (sh != '0) ? ALL : '0;
         end
         OP_SHR: begin
            res     = shr_x[W:1];
            cf      = shr_x[0];
            flg_upd = (sh != '0) ? ALL : '0;
         end
         OP_SAR: begin
            res     = sar_x[W:1];
            cf      = sar_x[0];
            flg_upd = (sh != '0) ? ALL : '0;
         end
         OP_XOR:  res = a ^ b;
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_NOT:  res = ~a;
         OP_TEST: fval = a & b;
         OP_INC: begin
            res     = inc_r;
            of      = ~a[MSB] & inc_r[MSB];
            flg_upd = NO_CF;
         end
         OP_DEC: begin
            res     = dec_r;
            of      = a[MSB] & ~dec_r[MSB];
            flg_upd = NO_CF;
         end
         OP_NEG: begin
            res = neg_r;
            cf  = |a;
            of  = a[MSB] & neg_r[MSB];
         end
         OP_SETB: flg_upd = '0;
         default: flg_upd = '0;
      endcase
      if (op != OP_CMP && op != OP_TEST) fval = res;
   end

   always_comb begin
      flg_new          = '0;
      flg_new[FLAG_CF] = cf;
      flg_new[FLAG_ZF] = (fval == ZERO);
      flg_new[FLAG_SF] = fval[MSB];
      flg_new[FLAG_OF] = of;
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import flag_alu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FLAG_N-1:0] upd,
   input  logic [FLAG_N-1:0] nxt,
   output logic [FLAG_N-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= (q & ~upd) | (nxt & upd);
   end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
   import flag_alu_pkg::*;
(
   input  logic [FLAG_N-1:0] flags,
   input  logic [3:0]        cc,
   output logic              take
);
   logic c, z, s, o, lt;
   assign c  = flags[FLAG_CF];
   assign z  = flags[FLAG_ZF];
   assign s  = flags[FLAG_SF];
   assign o  = flags[FLAG_OF];
   assign lt = s ^ o;

   always_comb begin
      case (cc_e'(cc))
         CC_EQ:     take = z;
         CC_NE:     take = ~z;
         CC_NEG:    take = s;
         CC_NNEG:   take = ~s;
         CC_GT:     take = ~lt & ~z;
         CC_GE:     take = ~lt;
         CC_LT:     take = lt;
         CC_LE:     take = lt | z;
         CC_AB:     take = ~c & ~z;
         CC_BL:     take = c;
         CC_ALWAYS: take = 1'b1;
         default:   take = 1'b0;
      endcase
   end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              op_wide,
   input  logic [XLEN-1:0]   src_a,
   input  logic [XLEN-1:0]   src_b,
   input  logic [3:0]        cond_sel,
   output logic [XLEN-1:0]   result,
   output logic [FLAG_N-1:0] flags_q,
   output logic              cond_true
);
   localparam int HALF  = XLEN / 2;
   localparam int LANES = 2;

   if (XLEN % 16 != 0 || XLEN < 16) begin : g_bad_xlen
      $error("flag_alu: XLEN must be a multiple of 16 and at least 16");
   end

   alu_op_e            op_e;
   logic [XLEN-1:0]    lane_res [LANES];
   logic [FLAG_N-1:0]  lane_new [LANES];
   logic [FLAG_N-1:0]  lane_upd [LANES];
   logic               sel;

   assign op_e = alu_op_e'(op_code);
   assign sel  = op_wide;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LW = (g == 0) ? HALF : XLEN;
      logic [LW-1:0] r;
      alu_lane #(.W(LW)) u_lane (
         .op      (op_e),
         .a       (src_a[LW-1:0]),
         .b       (src_b[LW-1:0]),
         .res     (r),
         .flg_new (lane_new[g]),
         .flg_upd (lane_upd[g])
      );
      assign lane_res[g] = XLEN'(r);
   end

   alu_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (op_valid),
      .upd   (lane_upd[sel]),
      .nxt   (lane_new[sel]),
      .q     (flags_q)
   );

   alu_cond_eval u_cond (
      .flags (flags_q),
      .cc    (cond_sel),
      .take  (cond_true)
   );

   always_comb begin
      case (op_e)
         OP_SETB:         result = {src_a[XLEN-1:8], 7'b0, cond_true};
         OP_CMP, OP_TEST: result = src_a;
         default:         result = lane_res[sel];
      endcase
   end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
   import flag_alu_pkg::*;
#(
   parameter int XLEN = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        op_code,
   input logic              op_wide,
   input logic [XLEN-1:0]   src_a,
   input logic [3:0]        cond_sel,
   input logic [XLEN-1:0]   result,
   input logic [FLAG_N-1:0] flags_q,
   input logic              cond_true
);
   localparam int HALF = XLEN / 2;

   logic is_logic, is_incdec, is_flagonly;
   assign is_logic    = op_code == OP_AND || op_code == OP_OR ||
                        op_code == OP_XOR || op_code == OP_NOT;
   assign is_incdec   = op_code == OP_INC || op_code == OP_DEC;
   assign is_flagonly = op_code == OP_CMP || op_code == OP_TEST;

   // R1
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(flags_q));
   // R7
   mul_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_MUL) |=> $stable(flags_q));
   // R6
   incdec_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_incdec) |=> flags_q[FLAG_CF] == $past(flags_q[FLAG_CF]));
   // R5
   logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_logic) |=> !flags_q[FLAG_CF] && !flags_q[FLAG_OF]);
   // R4
   cmp_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_flagonly) |-> result == src_a);
   // R9
   narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_wide && !is_flagonly && op_code != OP_SETB)
         |-> result[XLEN-1:HALF] == '0);
   // R11
   setb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SETB)
         |-> result[XLEN-1:8] == src_a[XLEN-1:8] && result[7:0] == {7'b0, cond_true});
   // R11
   setb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SETB) |=> $stable(flags_q));
   // R10
   always_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond_sel == CC_ALWAYS |-> cond_true);
   // R10
   below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond_sel == CC_BL |-> cond_true == flags_q[FLAG_CF]);
endmodule

bind flag_alu flag_alu_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .op_wide   (op_wide),
   .src_a     (src_a),
   .cond_sel  (cond_sel),
   .result    (result),
   .flags_q   (flags_q),
   .cond_true (cond_true)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        op_wide = 1'b1;
   logic [63:0] src_a = '0, src_b = '0;
   logic [3:0]  cond_sel = '0;
   logic [63:0] result;
   logic [3:0]  flags_q;
   logic        cond_true;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [3:0]  mf = '0;      // model flags {OF,SF,ZF,CF}
   logic [63:0] last_res;

   always #2 clk = ~clk;

   flag_alu i_flag_alu (.*);

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit cc_model(logic [3:0] f, logic [3:0] cc);
      bit c = f[0], z = f[1], s = f[2], o = f[3];
      case (cc)
         0: return z;            1: return !z;
         2: return s;            3: return !s;
         4: return (s == o) && !z;
         5: return s == o;       6: return s != o;
         7: return (s != o) || z;
         8: return !c && !z;     9: return c;
         10: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic logic signed [127:0] sx(logic [63:0] v, int w);
      if (w == 32) return {{96{v[31]}}, v[31:0]};
      return {{64{v[63]}}, v};
   endfunction

   function automatic bit ovf(logic signed [127:0] t, int w);
      logic signed [127:0] mx = (128'sd1 <<< (w - 1)) - 128'sd1;
      return (t > mx) || (t < -mx - 128'sd1);
   endfunction

   function automatic string req_of(logic [3:0] op);
      case (op)
         0: return "R2";  1, 11: return "R3";  13, 14: return "R4";
         6, 7, 8, 12: return "R5";  9, 10: return "R6";  2: return "R7";
         3, 4, 5: return "R8";  default: return "R11";
      endcase
   endfunction

   // behavioural reference: returns expected result, advances mf
   function automatic logic [63:0] model(logic [3:0] op, bit wide,
                                         logic [63:0] a, logic [63:0] b,
                                         logic [3:0] cc);
      int w = wide ? 64 : 32;
      logic [63:0] m = wide ? '1 : 64'hFFFF_FFFF;
      logic [63:0] ua = a & m, ub = b & m, r, fv;
      logic signed [127:0] sa = sx(a, w), sb = sx(b, w);
      logic [127:0] u;
      int sh = wide ? int'(b[5:0]) : int'(b[4:0]);
      bit cf = mf[0], of = mf[3], touch = 1;
      case (op)
         0: begin u = {64'b0, ua} + {64'b0, ub}; r = u[63:0] & m;
                  cf = u >= (128'd1 << w); of = ovf(sa + sb, w); fv = r; end
         1, 13: begin fv = (ua - ub) & m; cf = ua < ub; of = ovf(sa - sb, w);
                  r = (op == 1) ? fv : a; end
         2: begin r = (ua * ub) & m; touch = 0; end
         3: begin u = {64'b0, ua} << sh; r = u[63:0] & m; cf = u[w]; of = 0;
                  touch = sh != 0; fv = r; end
         4: begin r = 64'((sa >>> sh)) & m; if (sh != 0) cf = ua[sh-1];
                  of = 0; touch = sh != 0; fv = r; end
         5: begin r = ua >> sh; if (sh != 0) cf = ua[sh-1];
                  of = 0; touch = sh != 0; fv = r; end
         6: begin r = ua ^ ub; cf = 0; of = 0; fv = r; end
         7: begin r = ua & ub; cf = 0; of = 0; fv = r; end
         8: begin r = ua | ub; cf = 0; of = 0; fv = r; end
         12: begin r = ~ua & m; cf = 0; of = 0; fv = r; end
         14: begin fv = ua & ub; cf = 0; of = 0; r = a; end
         9: begin r = (ua + 1) & m; of = ovf(sa + 1, w); fv = r; end
         10: begin r = (ua - 1) & m; of = ovf(sa - 1, w); fv = r; end
         11: begin r = (64'd0 - ua) & m; cf = ua != 0; of = ovf(-sa, w); fv = r; end
         default: begin r = {a[63:8], 7'b0, cc_model(mf, cc)}; touch = 0; end
      endcase
      if (touch) mf = {of, fv[w-1], fv == 0, cf};
      return r;
   endfunction

   task automatic run(logic [3:0] op, bit wide, logic [63:0] a, logic [63:0] b,
                      logic [3:0] cc, string req);
      logic [63:0] exp;
      @(negedge clk);
      chk(flags_q == mf, "R12 flags", 64'(flags_q), 64'(mf));
      op_valid = 1; op_code = op; op_wide = wide; src_a = a; src_b = b; cond_sel = cc;
      #1;
      chk(cond_true == cc_model(mf, cc), "R10 cond", 64'(cond_true), 64'(cc_model(mf, cc)));
      exp = model(op, wide, a, b, cc);
      chk(result === exp, req, result, exp);
      last_res = result;
   endtask

   task automatic idle(logic [63:0] a);
      @(negedge clk);
      chk(flags_q == mf, "R12 flags", 64'(flags_q), 64'(mf));
      op_valid = 0; op_code = 4'd0; src_a = a; src_b = ~a;
      @(negedge clk);
      chk(flags_q == mf, "R1 idle hold", 64'(flags_q), 64'(mf));
   endtask

   task automatic sweep();
      for (int c = 0; c < 16; c++) run(4'd15, 1, 64'hA5A5_A5A5_A5A5_A5FF, 0, 4'(c), "R11");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int x, y, sw;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      @(negedge clk);
      chk(flags_q == 4'd0, "R1 reset", 64'(flags_q), 0);
      cond_sel = 4'd10; #1;
      chk(cond_true == 1, "R10 always", 64'(cond_true), 1);
      cond_sel = 4'd0; #1;
      chk(cond_true == 0, "R10 eq after reset", 64'(cond_true), 0);

      // R2 signed overflow, unsigned carry to zero
      run(0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0, "R2");
      sweep();
      run(0, 1, '1, 1, 0, "R2");
      sweep();
      // R9 32-bit carry with upper garbage
      run(0, 0, 64'h1234_5678_FFFF_FFFF, 64'hFFFF_0000_0000_0001, 0, "R9");
      chk(last_res[63:32] == 0, "R9 upper zero", last_res, 0);
      // R3 borrow, neg of min
      run(1, 1, 0, 1, 0, "R3");
      sweep();
      run(11, 0, 64'hFFFF_FFFF_8000_0000, 0, 0, "R3");
      run(11, 1, 0, 0, 0, "R3");
      // R4 compare equal and signed-less
      run(13, 1, 64'd55, 64'd55, 0, "R4");
      sweep();
      run(13, 0, 64'h0000_0000_8000_0000, 64'd1, 0, "R4");
      sweep();
      run(14, 1, 64'h8000_0000_0000_00F0, 64'h8000_0000_0000_000F, 0, "R4");
      // R5 logical clears CF/OF
      run(0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, "R2");
      run(7, 1, 64'hF0, 64'h0F, 0, "R5");
      run(12, 0, 64'h0, 0, 0, "R5");
      // R6 inc keeps CF
      run(0, 1, '1, 2, 0, "R2");
      run(9, 1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "R6");
      run(10, 0, 64'h0, 0, 0, "R6");
      // R7 multiply
      run(2, 1, 64'h1_0000_0003, 64'h1_0000_0005, 0, "R7");
      run(2, 0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, "R7");
      // R8 shifts incl. zero and masked counts
      run(4, 1, 64'h8000_0000_0000_0000, 64'd63, 0, "R8");
      run(5, 1, 64'h8000_0000_0000_0001, 64'd0, 0, "R8");
      run(3, 0, 64'h8000_0001, 64'd33, 0, "R8");
      run(5, 0, 64'hFFFF_FFFF_8000_0000, 64'd31, 0, "R8");
      // R8 sign fill chain against integer arithmetic
      x = -123456; y = 987654;
      sw = ((x ^ y) >>> 17) & 8185;
      run(6, 0, {32'hDEAD_BEEF, 32'(x)}, {32'h1111_1111, 32'(y)}, 0, "R8");
      run(4, 0, last_res, 64'd17, 0, "R8");
      run(7, 0, last_res, 64'd8185, 0, "R8");
      chk(last_res == 64'(unsigned'(sw)), "R8 chain", last_res, 64'(unsigned'(sw)));
      idle(64'hFFFF);
      // random stream
      for (int i = 0; i < 600; i++) begin
         logic [3:0] op = 4'($urandom);
         logic [63:0] a = {$urandom, $urandom}, b = {$urandom, $urandom};
         if (i % 3 == 0) b = b & 64'h3F;
         if (i % 7 == 0) a = {a[63], 63'(0)};
         run(op, 1'($urandom), a, b, 4'($urandom), req_of(op));
         if (i % 50 == 0) idle(a);
      end
      idle(0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule